// File: doc/BRIEF.md
# Integer Square Root Unit

This block computes the floor of the square root of an unsigned operand held in a 64-bit argument register. Software loads the argument as two 32-bit halves, sets a width bit in a control register to choose between a 32-bit operand (the low half only) and a 64-bit operand, and then pulses `start`. The unit uses the digit-by-digit method. Each clock retires two operand bits. The 32-bit root goes into a read-only result register, and `busy` stays high while a computation is in flight.

The first trial bit is seeded with the highest power of four that does not exceed the operand. This means small operands finish early: a computation takes one cycle per retired bit pair and never more than 32 cycles. Rewriting the argument or control register during a computation abandons the computation in flight and restarts it on the new values. A new `start` pulse does the same.

Top module: `isqrt_unit`

## Requirements
- R1: Register address map on `wr_addr`/`rd_addr`: 0 = control, 1 = argument bits 31:0, 2 = argument bits 63:32, 3 = root (read-only). In the control register, bit 0 is the width select (1 = 64-bit operand) and bit 15 reads as the busy flag. All other control bits read as zero. Reads are combinational.
- R2: After reset, the control register, both argument halves and the root read as zero, and `busy` is low.
- R3: With the width bit clear, only argument bits 31:0 form the operand. The value held in bits 63:32 has no effect on the root.
- R4: With the width bit set, all 64 argument bits form the operand.
- R5: The root is floor(sqrt(operand)) as a 32-bit value. An operand of 0 gives 0, and an all-ones 64-bit operand gives 0xFFFFFFFF.
- R6: A `start` pulse makes `busy` (and control bit 15) read 1 from the following cycle.
- R7: Let 4^p be the highest power of four not above a nonzero operand. `busy` stays high for exactly p+1 cycles, and for exactly 1 cycle when the operand is zero. This is never more than 32 cycles.
- R8: The root register keeps its previous value during a computation. It takes the new root in the same cycle that `busy` falls.
- R9: A write to the control or argument registers while `busy` is high restarts the computation with the updated values. A `start` pulse while `busy` is high also restarts it. In both cases the latency of R7 is counted from the restart.
- R10: Writes to address 3 are ignored and do not restart a computation. Writing bit 15 of the control register does not set the busy flag. A control write while idle does not start a computation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data |
| start | input | 1 | Start pulse |
| busy | output | 1 | Computation in flight |

## Verification
The assertions check on every cycle that:
- a start or restart raises `busy` in the next cycle;
- a finish drops `busy`;
- the root register changes only on a finish;
- the trial bit is never more than one-hot;
- a latency counter never runs past 32 cycles.

Only the bench scenarios can show that the root is numerically correct, that the upper argument half is ignored in 32-bit mode, and that busy lengths match the power-of-four rule exactly. The same holds for restarts caused by writes, where the bench compares results with an independent bitwise root search.

// File: rtl/isq_pkg.sv
package isq_pkg;
  typedef enum logic [1:0] {
    ISQ_CTRL   = 2'd0,
    ISQ_ARG_LO = 2'd1,
    ISQ_ARG_HI = 2'd2,
    ISQ_ROOT   = 2'd3
  } isq_addr_e;

  localparam int ISQ_WIDE_BIT = 0;
  localparam int ISQ_BUSY_BIT = 15;
endpackage

// File: rtl/isq_regs.sv
module isq_regs
  import isq_pkg::*;
#(
  parameter int PARAM_W = 64,
  parameter int BUS_W   = 32,
  parameter int RES_W   = PARAM_W / 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [BUS_W-1:0]   wr_data,
  input  logic [1:0]         rd_addr,
  output logic [BUS_W-1:0]   rd_data,
  input  logic               busy,
  input  logic               done_pulse,
  input  logic [RES_W-1:0]   done_root,
  output logic [PARAM_W-1:0] arg_nxt,
  output logic               wide_nxt,
  output logic               cfg_write,
  output logic [RES_W-1:0]   root_q
);
  localparam int HALF_W = PARAM_W / 2;

  logic [PARAM_W-1:0] arg_q;
  logic               wide_q;
  isq_addr_e          waddr, raddr;

  assign waddr = isq_addr_e'(wr_addr);
  assign raddr = isq_addr_e'(rd_addr);

  // next-state view so a restart sees the value written in the same cycle
  always_comb begin
    arg_nxt  = arg_q;
    wide_nxt = wide_q;
    if (wr_en) begin
      case (waddr)
        ISQ_CTRL:   wide_nxt = wr_data[ISQ_WIDE_BIT];
        ISQ_ARG_LO: arg_nxt[HALF_W-1:0] = wr_data[HALF_W-1:0];
        ISQ_ARG_HI: arg_nxt[PARAM_W-1:HALF_W] = wr_data[HALF_W-1:0];
        default:    ;
      endcase
    end
  end

  assign cfg_write = wr_en && (waddr != ISQ_ROOT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arg_q  <= '0;
      wide_q <= 1'b0;
      root_q <= '0;
    end else begin
      arg_q  <= arg_nxt;
      wide_q <= wide_nxt;
      if (done_pulse) root_q <= done_root;
    end
  end

  always_comb begin
    rd_data = '0;
    case (raddr)
      ISQ_CTRL: begin
        rd_data[ISQ_WIDE_BIT] = wide_q;
        rd_data[ISQ_BUSY_BIT] = busy;
      end
      ISQ_ARG_LO: rd_data = BUS_W'(arg_q[HALF_W-1:0]);
      ISQ_ARG_HI: rd_data = BUS_W'(arg_q[PARAM_W-1:HALF_W]);
      ISQ_ROOT:   rd_data = BUS_W'(root_q);
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/isq_seed.sv
module isq_seed #(
  parameter int PARAM_W = 64
) (
  input  logic [PARAM_W-1:0] operand,
  output logic [PARAM_W-1:0] seed
);
  localparam int PAIRS = PARAM_W / 2;

  logic [PAIRS-1:0] pair_nz;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    assign pair_nz[p] = |operand[2*p+1 -: 2];
  end

  // highest nonzero bit pair selects the starting power of four
  always_comb begin
    seed = '0;
    for (int p = 0; p < PAIRS; p++) begin
      if (pair_nz[p]) seed = PARAM_W'(1) << (2 * p);
    end
  end
endmodule

// File: rtl/isq_core.sv
module isq_core #(
  parameter int PARAM_W = 64,
  parameter int RES_W   = PARAM_W / 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [PARAM_W-1:0] operand,
  input  logic [PARAM_W-1:0] seed,
  output logic               busy,
  output logic               done_pulse,
  output logic [RES_W-1:0]   done_root,
  output logic               iter_fire,
  output logic [PARAM_W-1:0] bit_q
);
  typedef struct packed {
    logic [PARAM_W-1:0] rem;
    logic [PARAM_W-1:0] res;
    logic [PARAM_W-1:0] bitv;
  } step_t;

  // one digit-by-digit iteration: retires two operand bits
  function automatic step_t isq_step(input logic [PARAM_W-1:0] rem,
                                     input logic [PARAM_W-1:0] res,
                                     input logic [PARAM_W-1:0] bitv);
    step_t              s;
    logic [PARAM_W-1:0] trial;
    trial = res + bitv;
    if (rem >= trial) begin
      s.rem = rem - trial;
      s.res = (res >> 1) + bitv;
    end else begin
      s.rem = rem;
      s.res = res >> 1;
    end
    s.bitv = bitv >> 2;
    return s;
  endfunction

  logic [PARAM_W-1:0] rem_q, res_q;
  logic               busy_q;
  step_t              nx;
  logic               bit_zero, finish;

  assign nx        = isq_step(rem_q, res_q, bit_q);
  assign bit_zero  = (bit_q == '0);
  assign finish    = busy_q && (bit_zero || (nx.bitv == '0));
  assign done_pulse = finish && !load;
  assign iter_fire = busy_q && !bit_zero && !load;
  assign done_root = bit_zero ? res_q[RES_W-1:0] : nx.res[RES_W-1:0];
  assign busy      = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
      res_q  <= '0;
      bit_q  <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      rem_q  <= operand;
      res_q  <= '0;
      bit_q  <= seed;
    end else if (busy_q) begin
      if (finish) busy_q <= 1'b0;
      if (!bit_zero) begin
        rem_q <= nx.rem;
        res_q <= nx.res;
        bit_q <= nx.bitv;
      end
    end
  end
endmodule

// File: rtl/isqrt_unit.sv
module isqrt_unit #(
  parameter int PARAM_W = 64,
  parameter int BUS_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [BUS_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [BUS_W-1:0] rd_data,
  input  logic             start,
  output logic             busy
);
  localparam int RES_W  = PARAM_W / 2;
  localparam int HALF_W = PARAM_W / 2;

  logic [PARAM_W-1:0] arg_nxt, operand, seed, bit_q;
  logic               wide_nxt, cfg_write, load;
  logic               done_pulse, iter_fire;
  logic [RES_W-1:0]   done_root, root_q;

  isq_regs #(.PARAM_W(PARAM_W), .BUS_W(BUS_W), .RES_W(RES_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .done_pulse(done_pulse), .done_root(done_root),
    .arg_nxt(arg_nxt), .wide_nxt(wide_nxt), .cfg_write(cfg_write),
    .root_q(root_q)
  );

  assign operand = wide_nxt ? arg_nxt : PARAM_W'(arg_nxt[HALF_W-1:0]);
  assign load    = start || (cfg_write && busy);

  isq_seed #(.PARAM_W(PARAM_W)) u_seed (
    .operand(operand), .seed(seed)
  );

  isq_core #(.PARAM_W(PARAM_W), .RES_W(RES_W)) u_core (
    .clk(clk), .rst_n(rst_n), .load(load), .operand(operand), .seed(seed),
    .busy(busy), .done_pulse(done_pulse), .done_root(done_root),
    .iter_fire(iter_fire), .bit_q(bit_q)
  );
endmodule

module isqrt_unit_chk #(
  parameter int PARAM_W = 64,
  parameter int RES_W   = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               load,
  input logic               busy,
  input logic               done_pulse,
  input logic               iter_fire,
  input logic [RES_W-1:0]   root_q,
  input logic [PARAM_W-1:0] bit_q
);
  logic [7:0] lat_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     lat_q <= '0;
    else if (load)  lat_q <= 8'd1;
    else if (busy)  lat_q <= lat_q + 8'd1;
    else            lat_q <= '0;
  end

  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  p_restart_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy);
  p_done_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse && !load) |=> !busy);
  p_root_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_pulse |=> $stable(root_q));
  p_idle_no_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!done_pulse && !iter_fire));
  p_bit_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bit_q));
  p_latency_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (lat_q <= 8'(RES_W)));
endmodule

bind isqrt_unit isqrt_unit_chk #(.PARAM_W(PARAM_W), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .load(load), .busy(busy),
  .done_pulse(done_pulse), .iter_fire(iter_fire), .root_q(root_q),
  .bit_q(bit_q)
);

// File: tb/tb_isqrt_unit.sv
module tb_isqrt_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        start = 1'b0;
  logic        busy;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;
  logic [31:0] last_root = '0;

  always #4 clk = ~clk;

  isqrt_unit dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .start(start), .busy(busy)
  );

  // independent reference: bitwise root search with full products
  function automatic logic [31:0] ref_root(input logic [63:0] x);
    logic [31:0]  r = '0;
    logic [31:0]  c;
    logic [127:0] sq;
    for (int i = 31; i >= 0; i--) begin
      c  = r | (32'd1 << i);
      sq = {96'd0, c} * {96'd0, c};
      if (sq <= {64'd0, x}) r = c;
    end
    return r;
  endfunction

  function automatic int ref_lat(input logic [63:0] x);
    int msb = -1;
    for (int i = 0; i < 64; i++) if (x[i]) msb = i;
    return (msb < 0) ? 1 : (msb / 2) + 1;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic count_busy(output int lat);
    lat = 0;
    while (busy && lat < 100) begin
      lat++;
      @(negedge clk);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // full operation: load argument, choose width, start, check busy, root, latency
  task automatic run_op(input bit wide, input logic [63:0] arg, input bit deep);
    logic [63:0] opnd;
    logic [31:0] d, exp;
    int lat;
    opnd = wide ? arg : {32'd0, arg[31:0]};
    exp  = ref_root(opnd);
    wr(2'd0, {31'd0, wide});
    wr(2'd1, arg[31:0]);
    wr(2'd2, arg[63:32]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (deep) begin
      check("R6 busy after start", {63'd0, busy}, 64'd1);
      rd(2'd0, d);
      check("R6 control bit15", {63'd0, d[15]}, 64'd1);
      rd(2'd3, d);
      check("R8 root held while busy", {32'd0, d}, {32'd0, last_root});
    end
    count_busy(lat);
    if (deep || lat != ref_lat(opnd))
      check(wide ? "R7 latency wide" : "R7 latency narrow", lat, ref_lat(opnd));
    rd(2'd3, d);
    check(wide ? "R4 R5 wide root" : "R3 R5 narrow root", {32'd0, d}, {32'd0, exp});
    last_root = exp;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [31:0] d;
    logic [63:0] x;
    int lat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check("R2 reset register", {32'd0, d}, 64'd0);
    end
    check("R2 reset busy", {63'd0, busy}, 64'd0);

    // R1 register map readback
    wr(2'd1, 32'h1234_5678);
    wr(2'd2, 32'h9ABC_DEF0);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd1, d); check("R1 arg low", {32'd0, d}, 64'h1234_5678);
    rd(2'd2, d); check("R1 arg high", {32'd0, d}, 64'h9ABC_DEF0);
    rd(2'd0, d); check("R1 R10 control reads width only", {32'd0, d}, 64'h1);
    check("R10 control write idle no start", {63'd0, busy}, 64'd0);

    // R10 root write ignored
    run_op(1'b0, 64'd49, 1'b1);
    wr(2'd3, 32'hDEAD_BEEF);
    rd(2'd3, d); check("R10 root write ignored", {32'd0, d}, 64'd7);
    check("R10 root write no start", {63'd0, busy}, 64'd0);

    // R3/R5/R7 narrow sweep with garbage in the upper half
    for (int v = 0; v < 1024; v++)
      run_op(1'b0, {32'hA5A5_0F0F ^ 32'(v), 32'(v)}, (v % 128) == 0);

    // R4/R5/R7 wide boundaries around every power of four
    for (int k = 0; k < 32; k++) begin
      x = 64'd1 << (2 * k);
      run_op(1'b1, x, k == 31);
      run_op(1'b1, x - 64'd1, 1'b0);
      run_op(1'b1, x + 64'd1, 1'b0);
    end
    for (int k = 1; k < 32; k++) begin
      x = 64'd1 << k;
      run_op(1'b1, (x + 1) * (x + 1) - 64'd1, 1'b0);
      run_op(1'b1, (x - 1) * (x - 1), 1'b0);
    end
    run_op(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);  // R5 max -> FFFFFFFF
    run_op(1'b1, 64'd0, 1'b1);                    // R5 zero
    run_op(1'b0, 64'hFFFF_FFFF_0000_0000, 1'b1);  // R3 high ignored -> 0

    // pseudo-random wide operands
    x = 64'h0123_4567_89AB_CDEF;
    for (int n = 0; n < 300; n++) begin
      x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
      run_op(1'b1, x >> (n % 40), 1'b0);
    end

    // R9 argument write while busy restarts
    wr(2'd0, 32'd1);
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd2, 32'hFFFF_FFFF);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    wr(2'd2, 32'h0000_0010);
    check("R9 busy after restart write", {63'd0, busy}, 64'd1);
    count_busy(lat);
    check("R9 latency from restart", lat, ref_lat(64'h0000_0010_FFFF_FFFF));
    rd(2'd3, d);
    check("R9 root after restart", {32'd0, d}, {32'd0, ref_root(64'h0000_0010_FFFF_FFFF)});

    // R9 control write while busy switches width
    start = 1'b1; @(negedge clk); start = 1'b0;
    @(negedge clk);
    wr(2'd0, 32'd0);
    count_busy(lat);
    check("R9 latency after width change", lat, ref_lat(64'hFFFF_FFFF));
    rd(2'd3, d);
    check("R9 root after width change", {32'd0, d}, 64'hFFFF);

    // R9 start while busy restarts; R10 root write while busy does not
    wr(2'd0, 32'd1);
    wr(2'd2, 32'h4000_0000);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wr(2'd3, 32'h0);
    count_busy(lat);
    check("R9 R10 latency after restart start", lat, 32 - 1);
    rd(2'd3, d);
    check("R9 root after restart start", {32'd0, d}, {32'd0, ref_root(64'h4000_0000_FFFF_FFFF)});

    finish_up();
  end
endmodule